// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts a single PWM command into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a half bridge. It never enables both at once. Dead time is not a fixed count. Before a gate is turned on, the block waits for comparator feedback showing that the opposite switch has really turned off. A turn-on of the high gate needs the low-gate-voltage-below-threshold flag. A turn-on of the low gate needs the switch-node-below-threshold flag. If the switch node never drops, a timeout forces the low gate on anyway, so the bootstrap supply stays charged. A watchdog then ends that forced on-time if the node stays high for too long.

Gates are also held off in two other cases: until the supply monitor reports a good supply, with hysteresis between the rising and falling supply flags, and while a shutdown-window flag from an external three-level PWM detector has been held for a holdoff time. Every asynchronous input passes through a two-flop synchronizer before the state machine sees it. The shortest path from an input pin to a gate output is therefore three clock edges.

The state machine has eight states:
- OFF: both gates low. Once the supply is good it leaves on the PWM level: high goes to WAIT_LOW_OFF, low goes to WAIT_NODE_LOW.
- LOW_ON: low gate on. PWM high goes to WAIT_LOW_OFF.
- WAIT_LOW_OFF: both gates low. PWM low aborts to WAIT_NODE_LOW. The low-gate-low flag goes to HIGH_ON.
- HIGH_ON: high gate on. PWM low goes to WAIT_NODE_LOW.
- WAIT_NODE_LOW: both gates low. PWM high aborts to WAIT_LOW_OFF. The node-low flag goes to LOW_ON. Timeout expiry goes to FORCED_LOW.
- FORCED_LOW: low gate on while the node-high time is counted. PWM high goes to WAIT_LOW_OFF. Watchdog expiry goes to FAULT_HOLD.
- FAULT_HOLD: both gates low and the fault output set. Only a PWM rising edge leaves, to WAIT_LOW_OFF.
- SHUTDOWN: both gates low. When the shutdown flag clears it returns to OFF.

Two conditions override every state. Loss of supply-good sends the machine to OFF. A held shutdown window sends it to SHUTDOWN. Supply-good takes priority over shutdown.

Top module: `gate_sequencer`

## Requirements
- R1: After reset both gate enables, the fault output and the shutdown output are 0.
- R2: Supply-good sets when the rising-threshold flag is 1. It clears only when the falling-threshold flag is 0, so dropping only the rising flag leaves it set. While supply-good is 0 both gates stay low, whatever the PWM input does.
- R3: On PWM going high, the low gate turns off first. The high gate turns on only after the low-gate-below-threshold flag is 1, and it stays off for as long as that flag is 0.
- R4: On PWM going low, the high gate turns off first. The low gate turns on once the switch-node-below-threshold flag is 1.
- R5: If the node-low flag stays 0 for NODE_TMO_NS (default 250 ns, 25 cycles at the default 100 MHz) after the high gate turns off, the low gate is forced on.
- R6: During the forced low-side on-time, the node-high condition is timed. When it lasts without a break for WDOG_NS (default 2 us, 200 cycles), both gates go low and the fault output goes to 1. A single-cycle node-low pulse restarts that count.
- R7: In the fault hold, both gates stay low whatever the feedback flags do. Only a PWM rising edge clears the fault and restarts the rising sequence.
- R8: When the shutdown-window flag stays at 1 for HOLDOFF_CYC cycles (default 16), both gates are forced low and the shutdown output is 1, even if PWM changes. A shorter pulse has no effect. When the flag returns to 0, normal sequencing resumes.
- R9: A PWM edge that arrives during a feedback wait aborts the wait and starts the opposite sequence with both gates low. If a PWM edge and the awaited feedback flag arrive in the same cycle, the PWM edge takes priority.
- R10: The two gate enables are never 1 in the same cycle.
- R11: An input change applied between clock edges reaches the gate outputs after exactly three rising edges: two synchronizer stages and the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command (asynchronous) |
| shdn_win_in | input | 1 | 1 while the PWM input sits in the shutdown window |
| lg_below_in | input | 1 | 1 while the low-gate voltage is below its turn-off threshold |
| node_below_in | input | 1 | 1 while the switch node is below its low threshold |
| vcc_above_rise_in | input | 1 | 1 while the supply is above the rising threshold |
| vcc_above_fall_in | input | 1 | 1 while the supply is above the falling threshold |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| fault_hold | output | 1 | 1 while latched off after a node-high watchdog fault |
| shutdown_active | output | 1 | 1 while the shutdown window holds the gates off |

## Verification
The case that needs care is a PWM edge reaching the state machine in the same cycle as the feedback flag that the current wait is expecting. The first example is PWM dropping while the low-gate-low flag rises, in WAIT_LOW_OFF. The bench provokes this by changing both input pins at the same falling clock edge. Both signals pass through synchronizers of equal depth, so they reach the state machine together. The bench then checks every cycle that the high gate never pulses and that the low gate comes on. A second pairing is a node-low pulse arriving in the cycles just before the watchdog limit. The bench checks that such a pulse postpones the fault rather than letting it fire.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_LOW_ON,
        S_WAIT_LOW_OFF,
        S_HIGH_ON,
        S_WAIT_NODE_LOW,
        S_FORCED_LOW,
        S_FAULT_HOLD,
        S_SHUTDOWN
    } gsq_state_e;

    // clock cycles covering a duration in nanoseconds, at least one
    function automatic int ns_to_cycles(input longint clk_hz, input longint dur_ns);
        longint c;
        c = (clk_hz * dur_ns) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gsq_sat_cnt.sv
module gsq_sat_cnt #(
    parameter int LIMIT = 25,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_limit
);

    assign at_limit = (cnt == W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clr)            cnt <= '0;
        else if (inc && !at_limit) cnt <= cnt + 1'b1;
    end

    p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(LIMIT));

endmodule

// File: rtl/gsq_supply_mon.sv
module gsq_supply_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic above_rise,
    input  logic above_fall,
    output logic supply_ok
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         supply_ok <= 1'b0;
        else if (supply_ok) supply_ok <= above_fall;
        else                supply_ok <= above_rise;
    end

    p_hyst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && above_fall) |=> supply_ok);

    p_hyst_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !above_fall) |=> !supply_ok);

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
    import gsq_pkg::*;
#(
    parameter longint CLK_HZ      = 100_000_000,
    parameter int     NODE_TMO_NS = 250,
    parameter int     WDOG_NS     = 2000,
    parameter int     HOLDOFF_CYC = 16,
    parameter int     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic shdn_win_in,
    input  logic lg_below_in,
    input  logic node_below_in,
    input  logic vcc_above_rise_in,
    input  logic vcc_above_fall_in,
    output logic hs_gate_en,
    output logic ls_gate_en,
    output logic fault_hold,
    output logic shutdown_active
);

    localparam int NODE_TMO_CYC = ns_to_cycles(CLK_HZ, NODE_TMO_NS);
    localparam int WDOG_CYC     = ns_to_cycles(CLK_HZ, WDOG_NS);
    localparam int N_IN         = 6;

    // synchronized inputs
    logic [N_IN-1:0] raw_in, syn_in;
    logic pwm_s, sd_s, lg_s, node_s, rise_s, fall_s;

    assign raw_in = {pwm_in, shdn_win_in, lg_below_in, node_below_in,
                     vcc_above_rise_in, vcc_above_fall_in};

    gsq_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    assign {pwm_s, sd_s, lg_s, node_s, rise_s, fall_s} = syn_in;

    // PWM edge detection on the synchronized level
    logic pwm_q, pwm_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_s;
    end

    assign pwm_rise = pwm_s && !pwm_q;

    // supply-good with hysteresis
    logic supply_ok;

    gsq_supply_mon u_supply (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_rise (rise_s),
        .above_fall (fall_s),
        .supply_ok  (supply_ok)
    );

    gsq_state_e state, state_nxt;

    // node-low timeout, node-high watchdog, shutdown holdoff
    logic [$clog2(NODE_TMO_CYC):0] tmo_cnt;
    logic [$clog2(WDOG_CYC):0]     wdg_cnt;
    logic [$clog2(HOLDOFF_CYC+1)-1:0] hld_cnt;
    logic tmo_hit, wdg_hit, sd_hold;

    gsq_sat_cnt #(.LIMIT(NODE_TMO_CYC - 1)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state != S_WAIT_NODE_LOW),
        .inc      (1'b1),
        .cnt      (tmo_cnt[$clog2(NODE_TMO_CYC)-1:0]),
        .at_limit (tmo_hit)
    );
    assign tmo_cnt[$clog2(NODE_TMO_CYC)] = 1'b0;

    gsq_sat_cnt #(.LIMIT(WDOG_CYC - 1)) u_wdg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      ((state != S_FORCED_LOW) || node_s),
        .inc      (1'b1),
        .cnt      (wdg_cnt[$clog2(WDOG_CYC)-1:0]),
        .at_limit (wdg_hit)
    );
    assign wdg_cnt[$clog2(WDOG_CYC)] = 1'b0;

    gsq_sat_cnt #(.LIMIT(HOLDOFF_CYC)) u_hld (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!sd_s),
        .inc      (1'b1),
        .cnt      (hld_cnt),
        .at_limit (sd_hold)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (!supply_ok) begin
            state_nxt = S_OFF;
        end else if (sd_hold) begin
            state_nxt = S_SHUTDOWN;
        end else begin
            unique case (state)
                S_OFF:           state_nxt = pwm_s ? S_WAIT_LOW_OFF : S_WAIT_NODE_LOW;
                S_LOW_ON:        if (pwm_s) state_nxt = S_WAIT_LOW_OFF;
                S_WAIT_LOW_OFF: begin
                    if (!pwm_s)    state_nxt = S_WAIT_NODE_LOW;
                    else if (lg_s) state_nxt = S_HIGH_ON;
                end
                S_HIGH_ON:       if (!pwm_s) state_nxt = S_WAIT_NODE_LOW;
                S_WAIT_NODE_LOW: begin
                    if (pwm_s)        state_nxt = S_WAIT_LOW_OFF;
                    else if (node_s)  state_nxt = S_LOW_ON;
                    else if (tmo_hit) state_nxt = S_FORCED_LOW;
                end
                S_FORCED_LOW: begin
                    if (pwm_s)        state_nxt = S_WAIT_LOW_OFF;
                    else if (wdg_hit) state_nxt = S_FAULT_HOLD;
                end
                S_FAULT_HOLD:    if (pwm_rise) state_nxt = S_WAIT_LOW_OFF;
                S_SHUTDOWN:      state_nxt = S_OFF;
                default:         state_nxt = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nxt;
    end

    // output decode
    always_comb begin
        hs_gate_en      = 1'b0;
        ls_gate_en      = 1'b0;
        fault_hold      = 1'b0;
        shutdown_active = 1'b0;
        unique case (state)
            S_LOW_ON,
            S_FORCED_LOW:  ls_gate_en      = 1'b1;
            S_HIGH_ON:     hs_gate_en      = 1'b1;
            S_FAULT_HOLD:  fault_hold      = 1'b1;
            S_SHUTDOWN:    shutdown_active = 1'b1;
            default:       ;
        endcase
    end

    // assertions
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_en && ls_gate_en));

    p_supply_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_gate_en && !ls_gate_en));

    p_high_after_lgate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_en) |-> $past(lg_s));

    p_low_after_node_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_gate_en) && $past(state == S_WAIT_NODE_LOW)) |-> $past(node_s || tmo_hit));

    p_handover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_en) |-> !$past(hs_gate_en));

    p_wdog_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FORCED_LOW && wdg_hit && supply_ok && !sd_hold && !pwm_s) |=> fault_hold);

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_hold && !pwm_rise && supply_ok && !sd_hold) |=> fault_hold);

    p_shutdown_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_hold && supply_ok) |=> (shutdown_active && !hs_gate_en && !ls_gate_en));

endmodule

// File: tb/tb_gate_sequencer.sv
module tb_gate_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int HOLDOFF    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm = 0, sd = 0, lgl = 0, nodel = 0, vrise = 0, vfall = 0;
    logic hs, ls, flt, sda;

    int checks = 0;
    int fails  = 0;
    int overlap_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_sequencer #(.HOLDOFF_CYC(HOLDOFF)) dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .pwm_in            (pwm),
        .shdn_win_in       (sd),
        .lg_below_in       (lgl),
        .node_below_in     (nodel),
        .vcc_above_rise_in (vrise),
        .vcc_above_fall_in (vfall),
        .hs_gate_en        (hs),
        .ls_gate_en        (ls),
        .fault_hold        (flt),
        .shutdown_active   (sda)
    );

    always @(negedge clk) if (rst_n && hs && ls) overlap_seen++;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(hs == 0 && ls == 0, "R1 gates after reset", {hs, ls}, 0);
        chk(flt == 0 && sda == 0, "R1 fault/shutdown after reset", {flt, sda}, 0);
    endtask

    task automatic t_supply();
        nodel = 1; pwm = 0;
        cyc(10); chk(ls == 0, "R2 no supply keeps low gate off", ls, 0);
        vfall = 1;
        cyc(6);  chk(ls == 0, "R2 falling flag alone not enough", ls, 0);
        vrise = 1;
        cyc(6);  chk(ls == 1, "R2 rising flag enables", ls, 1);
        vrise = 0;
        cyc(6);  chk(ls == 1, "R2 hysteresis holds", ls, 1);
        vfall = 0;
        cyc(6);  chk(ls == 0 && hs == 0, "R2 falling threshold drops", {hs, ls}, 0);
        vfall = 1;
        cyc(6);  chk(ls == 0, "R2 needs rising threshold again", ls, 0);
        vrise = 1;
        cyc(6);  chk(ls == 1, "R2 re-enabled", ls, 1);
    endtask

    task automatic t_rise();
        lgl = 0; pwm = 1;
        cyc(2);  chk(ls == 1, "R11 low gate still on after two edges", ls, 1);
        cyc(1);  chk(ls == 0, "R11 low gate off after third edge", ls, 0);
        cyc(10); chk(hs == 0, "R3 high gate waits for low-gate flag", hs, 0);
        lgl = 1;
        cyc(4);  chk(hs == 1 && ls == 0, "R3 high gate on after flag", {hs, ls}, 2);
    endtask

    task automatic t_fall();
        nodel = 0; pwm = 0;
        cyc(3);  chk(hs == 0, "R4 high gate off first", hs, 0);
        cyc(5);  chk(ls == 0, "R4 low gate waits for node flag", ls, 0);
        nodel = 1;
        cyc(4);  chk(ls == 1, "R4 low gate on after node flag", ls, 1);
    endtask

    task automatic t_abort();
        int bad;
        pwm = 1; cyc(5);
        chk(hs == 1, "R9 setup high gate", hs, 1);
        lgl = 0; nodel = 0; pwm = 0;
        cyc(8);
        pwm = 1; bad = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (hs || ls) bad++;
        end
        chk(bad == 0, "R9 abort keeps both low", bad, 0);
        lgl = 1;
        cyc(4);  chk(hs == 1, "R9 rising sequence completes", hs, 1);
    endtask

    task automatic t_same_cycle();
        int bad;
        nodel = 1; pwm = 0;
        cyc(5);  chk(ls == 1, "R9 setup low gate", ls, 1);
        lgl = 0; pwm = 1;
        cyc(6);
        pwm = 0; lgl = 1; bad = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (hs) bad++;
        end
        chk(bad == 0, "R9 PWM wins over same-cycle flag", bad, 0);
        chk(ls == 1, "R9 low gate after abort", ls, 1);
    endtask

    task automatic t_timeout_wdog();
        pwm = 1; lgl = 1;
        cyc(5);  chk(hs == 1, "R5 setup high gate", hs, 1);
        nodel = 0; pwm = 0;
        cyc(23); chk(ls == 0 && hs == 0, "R5 before timeout", {hs, ls}, 0);
        cyc(10); chk(ls == 1, "R5 forced low gate", ls, 1);
        cyc(150); chk(ls == 1 && flt == 0, "R6 before watchdog", {flt, ls}, 1);
        nodel = 1; cyc(1); nodel = 0;
        cyc(150); chk(ls == 1 && flt == 0, "R6 node pulse restarts count", {flt, ls}, 1);
        cyc(80); chk(flt == 1 && ls == 0 && hs == 0, "R6 watchdog fault", {flt, hs, ls}, 4);
    endtask

    task automatic t_fault_hold();
        nodel = 1; lgl = 1;
        cyc(10); chk(flt == 1 && ls == 0 && hs == 0, "R7 flags ignored in fault", {flt, hs, ls}, 4);
        pwm = 1;
        cyc(6);  chk(flt == 0 && hs == 1, "R7 rising edge clears fault", {flt, hs}, 1);
    endtask

    task automatic t_shutdown();
        int bad;
        pwm = 0; nodel = 1;
        cyc(5);  chk(ls == 1, "R8 setup low gate", ls, 1);
        sd = 1; bad = 0;
        for (int i = 0; i < HOLDOFF/2; i++) begin
            cyc(1);
            if (!ls || sda) bad++;
        end
        sd = 0;
        for (int i = 0; i < 5; i++) begin
            cyc(1);
            if (!ls || sda) bad++;
        end
        chk(bad == 0, "R8 short pulse ignored", bad, 0);
        sd = 1;
        cyc(4);  chk(ls == 1 && sda == 0, "R8 holdoff not yet elapsed", {sda, ls}, 1);
        cyc(20); chk(ls == 0 && hs == 0 && sda == 1, "R8 shutdown forces off", {sda, hs, ls}, 4);
        pwm = 1;
        cyc(5);  chk(hs == 0, "R8 PWM ignored in shutdown", hs, 0);
        pwm = 0; sd = 0;
        cyc(6);  chk(ls == 1 && sda == 0, "R8 resumes after flag clears", {sda, ls}, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_supply();
        t_rise();
        t_fall();
        t_abort();
        t_same_cycle();
        t_timeout_wdog();
        t_fault_hold();
        t_shutdown();
        chk(overlap_seen == 0, "R10 gates never both on", overlap_seen, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule